// File: doc/BRIEF.md
# HDLC Host-Side Buffer and Interrupt Interface

This block sits between the processor bus and the line side of an HDLC controller. Received frame bytes arrive one per cycle on a byte stream with an end-of-frame marker. They are collected into a receive buffer that holds one block. When a block fills in the middle of a frame, or when the frame ends, the block is frozen and an interrupt event is raised. The host then drains the block through a 32-address window whose internal read pointer moves forward on every access, so string-move instructions work. After draining, the host hands the block back with a release command.

Transmit data goes the other way through the same window. Host writes land at an incrementing write pointer. A send command passes the filled buffer to the line side, which pulls the bytes with a ready/valid handshake. Once the last byte has been taken, a transmit-pool-ready event tells the host that the buffer may be refilled. An 8-bit interrupt status register collects the events and clears when it is read. Its bits are ORed onto a single interrupt line.

Top module: `hdlc_host_fifo_if`

## Requirements
- R1: A bus read at any address 0x00–0x1F returns the next received byte in arrival order, and the read pointer advances after every such read, whatever address is used.
- R2: When the 32nd byte of a block arrives without the end-of-frame marker, bit 6 (pool full) of the status register at 0x20 is set and the block is held for the host.
- R3: A byte that carries the end-of-frame marker sets bit 7 (message end) at 0x20. The register at 0x25 then gives, in bits 5:0, the number of valid bytes in that final block (1 to 32).
- R4: The status register at 0x20 reads 0x00 after reset. Bits 7/6/5/4 are message end, pool full, status change and transmit ready; bits 3:0 read 0. Output irq is high whenever any bit is set.
- R5: Reading 0x20 clears every bit it returned. An event that occurs in the same cycle as the read is kept for the next read.
- R6: A one-cycle pulse on rsc_pulse sets bit 5 at 0x20.
- R7: A write to 0x21 with bit 7 set, while a block is held, restarts the read pointer at 0 and resumes collection into an empty buffer. Such a write is ignored while no block is held, and so is a write with bit 7 clear.
- R8: A received byte that arrives while a block is held is dropped, and it sets bit 0 of the register at 0x27. That bit stays set until 0x27 is read, and the read clears it.
- R9: Host writes to 0x00–0x1F fill the transmit buffer in order at an incrementing pointer. Writes beyond 32 bytes are dropped.
- R10: A write to 0x21 with bit 3 set hands a non-empty transmit buffer to the line side. There tx_valid is high, tx_data presents the bytes in write order, each advancing when tx_ready is high, and tx_last marks the final byte. A send request with an empty buffer is ignored.
- R11: When the line side takes the final byte, bit 4 (transmit ready) at 0x20 is set and the buffer is returned to the host. Host writes made while the line side owns the buffer are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_sel | input | 1 | Bus access strobe, one access per cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 6 | Byte address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid in the cycle of the read |
| irq | output | 1 | OR of all status bits |
| rx_valid | input | 1 | Received byte present |
| rx_data | input | 8 | Received byte |
| rx_last | input | 1 | Byte closes the frame |
| rsc_pulse | input | 1 | Remote ready status changed |
| tx_ready | input | 1 | Line side takes the current byte |
| tx_valid | output | 1 | Transmit byte available |
| tx_data | output | 8 | Transmit byte |
| tx_last | output | 1 | Current byte is the last of the buffer |

## Verification
A read pointer that drifts shows up on the very next window read as a byte from the wrong position, or one shifted relative to the stream that was sent. A byte count off by one is visible as soon as 0x25 is read after a message-end event. A block that is wrongly left unheld, or held when it should not be, shows on the next received byte: the overflow bit at 0x27 is set or stays clear when it should not. Transmit pointer faults appear as the first wrong tx_data or a misplaced tx_last during the drain, and a missing hand-back appears as a missing transmit-ready bit right after the final pop.

// File: rtl/hfi_pkg.sv
package hfi_pkg;
  localparam int unsigned ADDR_W = 6;

  // register map
  localparam logic [ADDR_W-1:0] ADR_ISTA = 6'h20;
  localparam logic [ADDR_W-1:0] ADR_CMD  = 6'h21;
  localparam logic [ADDR_W-1:0] ADR_RCNT = 6'h25;
  localparam logic [ADDR_W-1:0] ADR_STAT = 6'h27;

  // command bits at ADR_CMD
  localparam int unsigned CMD_RX_RELEASE = 7;
  localparam int unsigned CMD_TX_SEND    = 3;

  // events feeding the status register
  typedef struct packed {
    logic msg_end;
    logic pool_full;
    logic stat_chg;
    logic tx_ready;
  } hfi_evt_t;
endpackage

// File: rtl/hfi_rst_sync.sv
module hfi_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_ns
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_ns = sync_q[STAGES-1];
endmodule

// File: rtl/hfi_rx_buf.sv
module hfi_rx_buf #(
  parameter int unsigned DW    = 8,
  parameter int unsigned DEPTH = 32
) (
  input  logic             clk,
  input  logic             rst_ns,
  input  logic             rx_valid,
  input  logic [DW-1:0]    rx_data,
  input  logic             rx_last,
  input  logic             rd_en,
  input  logic             release_req,
  input  logic             stat_rd,
  output logic [DW-1:0]    rd_data,
  output logic             pool_full_evt,
  output logic             msg_end_evt,
  output logic [$clog2(DEPTH):0] final_cnt,
  output logic             overflow
);
  localparam int unsigned PTR_W = $clog2(DEPTH);
  localparam int unsigned CNT_W = PTR_W + 1;
  localparam logic [CNT_W-1:0] FULL = CNT_W'(DEPTH);
  localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);

  logic [DW-1:0]    mem_q [DEPTH];
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [PTR_W-1:0] rd_ptr_q, rd_ptr_d;
  logic             held_q, held_d;
  logic [CNT_W-1:0] fin_q, fin_d;
  logic             ovf_q, ovf_d;
  logic             push, drop, do_release;

  assign push       = rx_valid & ~held_q;
  assign drop       = rx_valid &  held_q;
  assign do_release = release_req & held_q;

  always_comb begin
    cnt_d    = cnt_q;
    rd_ptr_d = rd_ptr_q;
    held_d   = held_q;
    fin_d    = fin_q;
    ovf_d    = drop | (ovf_q & ~stat_rd);
    if (rd_en) rd_ptr_d = rd_ptr_q + 1'b1;
    if (do_release) begin
      cnt_d    = '0;
      rd_ptr_d = '0;
      held_d   = 1'b0;
    end else if (push) begin
      cnt_d = cnt_q + ONE;
      if (rx_last) begin
        held_d = 1'b1;
        fin_d  = cnt_q + ONE;
      end else if (cnt_q == FULL - ONE) begin
        held_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) begin
      cnt_q    <= '0;
      rd_ptr_q <= '0;
      held_q   <= 1'b0;
      fin_q    <= '0;
      ovf_q    <= 1'b0;
    end else begin
      cnt_q    <= cnt_d;
      rd_ptr_q <= rd_ptr_d;
      held_q   <= held_d;
      fin_q    <= fin_d;
      ovf_q    <= ovf_d;
    end
  end

  // storage: write enable only, no reset
  always_ff @(posedge clk) begin
    if (push) mem_q[cnt_q[PTR_W-1:0]] <= rx_data;
  end

  assign rd_data       = mem_q[rd_ptr_q];
  assign pool_full_evt = push & ~rx_last & (cnt_q == FULL - ONE);
  assign msg_end_evt   = push & rx_last;
  assign final_cnt     = fin_q;
  assign overflow      = ovf_q;

  assert_block_full_R2: assert property (@(posedge clk) disable iff (!rst_ns)
    pool_full_evt |=> (held_q && cnt_q == FULL));

  assert_final_count_R3: assert property (@(posedge clk) disable iff (!rst_ns)
    msg_end_evt |=> (held_q && fin_q == cnt_q && fin_q != '0));

  assert_release_R7: assert property (@(posedge clk) disable iff (!rst_ns)
    do_release |=> (rd_ptr_q == '0 && cnt_q == '0 && !held_q));

  assert_drop_R8: assert property (@(posedge clk) disable iff (!rst_ns)
    (drop && !release_req) |=> ($stable(cnt_q) && ovf_q));

  assert_count_bound_R2: assert property (@(posedge clk) disable iff (!rst_ns)
    cnt_q <= FULL);
endmodule

// File: rtl/hfi_tx_buf.sv
module hfi_tx_buf #(
  parameter int unsigned DW    = 8,
  parameter int unsigned DEPTH = 32
) (
  input  logic          clk,
  input  logic          rst_ns,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  input  logic          send_req,
  input  logic          tx_ready,
  output logic          tx_valid,
  output logic [DW-1:0] tx_data,
  output logic          tx_last,
  output logic          xpr_evt
);
  localparam int unsigned PTR_W = $clog2(DEPTH);
  localparam int unsigned CNT_W = PTR_W + 1;
  localparam logic [CNT_W-1:0] FULL = CNT_W'(DEPTH);
  localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);

  logic [DW-1:0]    mem_q [DEPTH];
  logic [CNT_W-1:0] wcnt_q, wcnt_d;
  logic [PTR_W-1:0] rptr_q, rptr_d;
  logic             line_q, line_d;
  logic             host_wr, pop, at_last;

  assign host_wr = wr_en & ~line_q & (wcnt_q != FULL);
  assign at_last = ({1'b0, rptr_q} + ONE) == wcnt_q;
  assign pop     = line_q & tx_ready;

  always_comb begin
    wcnt_d  = wcnt_q;
    rptr_d  = rptr_q;
    line_d  = line_q;
    xpr_evt = 1'b0;
    if (host_wr) wcnt_d = wcnt_q + ONE;
    if (send_req && !line_q && wcnt_q != '0) begin
      line_d = 1'b1;
      rptr_d = '0;
    end
    if (pop) begin
      if (at_last) begin
        line_d  = 1'b0;
        wcnt_d  = '0;
        xpr_evt = 1'b1;
      end else begin
        rptr_d = rptr_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) begin
      wcnt_q <= '0;
      rptr_q <= '0;
      line_q <= 1'b0;
    end else begin
      wcnt_q <= wcnt_d;
      rptr_q <= rptr_d;
      line_q <= line_d;
    end
  end

  always_ff @(posedge clk) begin
    if (host_wr) mem_q[wcnt_q[PTR_W-1:0]] <= wr_data;
  end

  assign tx_valid = line_q;
  assign tx_data  = mem_q[rptr_q];
  assign tx_last  = line_q & at_last;

  assert_write_cap_R9: assert property (@(posedge clk) disable iff (!rst_ns)
    wcnt_q <= FULL);

  assert_read_inside_R10: assert property (@(posedge clk) disable iff (!rst_ns)
    line_q |-> ({1'b0, rptr_q} < wcnt_q));

  assert_host_locked_R11: assert property (@(posedge clk) disable iff (!rst_ns)
    (line_q && !tx_ready) |=> (line_q && $stable(wcnt_q) && $stable(rptr_q)));

  assert_handback_R11: assert property (@(posedge clk) disable iff (!rst_ns)
    xpr_evt |=> (!line_q && wcnt_q == '0));
endmodule

// File: rtl/hfi_irq_reg.sv
module hfi_irq_reg
  import hfi_pkg::*;
(
  input  logic     clk,
  input  logic     rst_ns,
  input  hfi_evt_t evt,
  input  logic     ista_rd,
  output logic [7:0] ista,
  output logic     irq
);
  logic [7:0] ista_q, ista_d, set_vec;

  assign set_vec = {evt.msg_end, evt.pool_full, evt.stat_chg, evt.tx_ready, 4'b0000};

  always_comb begin
    ista_d = ista_q;
    if (ista_rd) ista_d = '0;
    ista_d = ista_d | set_vec;
  end

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) ista_q <= '0;
    else         ista_q <= ista_d;
  end

  assign ista = ista_q;
  assign irq  = |ista_q;

  assert_read_clears_R5: assert property (@(posedge clk) disable iff (!rst_ns)
    (ista_rd && set_vec == '0) |=> (ista_q == '0));

  assert_event_kept_R5: assert property (@(posedge clk) disable iff (!rst_ns)
    (|set_vec) |=> irq);

  assert_low_nibble_R4: assert property (@(posedge clk) disable iff (!rst_ns)
    ista_q[3:0] == 4'b0000);
endmodule

// File: rtl/hdlc_host_fifo_if.sv
module hdlc_host_fifo_if
  import hfi_pkg::*;
#(
  parameter int unsigned DW    = 8,
  parameter int unsigned DEPTH = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DW-1:0]     bus_wdata,
  output logic [DW-1:0]     bus_rdata,
  output logic              irq,
  input  logic              rx_valid,
  input  logic [DW-1:0]     rx_data,
  input  logic              rx_last,
  input  logic              rsc_pulse,
  input  logic              tx_ready,
  output logic              tx_valid,
  output logic [DW-1:0]     tx_data,
  output logic              tx_last
);
  localparam int unsigned CNT_W = $clog2(DEPTH) + 1;

  logic              rst_ns;
  logic              in_win, rd_acc, wr_acc;
  logic              win_rd, win_wr, ista_rd, stat_rd, cmd_wr;
  logic [DW-1:0]     rx_rd_data;
  logic              pool_full_evt, msg_end_evt, xpr_evt, ovf;
  logic [CNT_W-1:0]  final_cnt;
  logic [7:0]        ista;
  hfi_evt_t          evt;

  hfi_rst_sync #(.STAGES(2)) u_rst (
    .clk    (clk),
    .rst_n  (rst_n),
    .rst_ns (rst_ns)
  );

  assign in_win  = bus_addr < ADDR_W'(DEPTH);
  assign rd_acc  = bus_sel & ~bus_we;
  assign wr_acc  = bus_sel &  bus_we;
  assign win_rd  = rd_acc & in_win;
  assign win_wr  = wr_acc & in_win;
  assign ista_rd = rd_acc & (bus_addr == ADR_ISTA);
  assign stat_rd = rd_acc & (bus_addr == ADR_STAT);
  assign cmd_wr  = wr_acc & (bus_addr == ADR_CMD);

  hfi_rx_buf #(.DW(DW), .DEPTH(DEPTH)) u_rx (
    .clk           (clk),
    .rst_ns        (rst_ns),
    .rx_valid      (rx_valid),
    .rx_data       (rx_data),
    .rx_last       (rx_last),
    .rd_en         (win_rd),
    .release_req   (cmd_wr & bus_wdata[CMD_RX_RELEASE]),
    .stat_rd       (stat_rd),
    .rd_data       (rx_rd_data),
    .pool_full_evt (pool_full_evt),
    .msg_end_evt   (msg_end_evt),
    .final_cnt     (final_cnt),
    .overflow      (ovf)
  );

  hfi_tx_buf #(.DW(DW), .DEPTH(DEPTH)) u_tx (
    .clk      (clk),
    .rst_ns   (rst_ns),
    .wr_en    (win_wr),
    .wr_data  (bus_wdata),
    .send_req (cmd_wr & bus_wdata[CMD_TX_SEND]),
    .tx_ready (tx_ready),
    .tx_valid (tx_valid),
    .tx_data  (tx_data),
    .tx_last  (tx_last),
    .xpr_evt  (xpr_evt)
  );

  assign evt.msg_end   = msg_end_evt;
  assign evt.pool_full = pool_full_evt;
  assign evt.stat_chg  = rsc_pulse;
  assign evt.tx_ready  = xpr_evt;

  hfi_irq_reg u_irq (
    .clk     (clk),
    .rst_ns  (rst_ns),
    .evt     (evt),
    .ista_rd (ista_rd),
    .ista    (ista),
    .irq     (irq)
  );

  always_comb begin
    bus_rdata = '0;
    if (rd_acc) begin
      if (in_win)                      bus_rdata = rx_rd_data;
      else if (bus_addr == ADR_ISTA)   bus_rdata = DW'(ista);
      else if (bus_addr == ADR_RCNT)   bus_rdata = DW'(final_cnt);
      else if (bus_addr == ADR_STAT)   bus_rdata = DW'(ovf);
    end
  end

  assert_status_change_R6: assert property (@(posedge clk) disable iff (!rst_ns)
    rsc_pulse |=> ista[5]);
endmodule

// File: tb/tb_hdlc_host_fifo_if.sv
module tb_hdlc_host_fifo_if;
  localparam int CLK_P = 10;

  logic       clk, rst_n;
  logic       bus_sel, bus_we;
  logic [5:0] bus_addr;
  logic [7:0] bus_wdata, bus_rdata;
  logic       irq;
  logic       rx_valid, rx_last, rsc_pulse, tx_ready;
  logic [7:0] rx_data, tx_data;
  logic       tx_valid, tx_last;

  int total = 0;
  int bad   = 0;

  hdlc_host_fifo_if dut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq(irq), .rx_valid(rx_valid), .rx_data(rx_data), .rx_last(rx_last),
    .rsc_pulse(rsc_pulse), .tx_ready(tx_ready), .tx_valid(tx_valid),
    .tx_data(tx_data), .tx_last(tx_last)
  );

  initial clk = 1'b0;
  always #(CLK_P/2) clk = ~clk;

  function automatic logic [7:0] exp_ista(input logic me, pf, sc, xr);
    return {me, pf, sc, xr, 4'b0000};
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic bus_rd(input logic [5:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
    @(posedge clk); #1 bus_sel = 1'b0;
  endtask

  task automatic bus_wr(input logic [5:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #1 bus_sel = 1'b0; bus_we = 1'b0;
  endtask

  task automatic rx_push(input logic [7:0] d, input logic last);
    @(negedge clk);
    rx_valid = 1'b1; rx_data = d; rx_last = last;
    @(posedge clk); #1 rx_valid = 1'b0; rx_last = 1'b0;
  endtask

  // one frame through the receive path, block by block
  task automatic rx_frame(input int len);
    logic [7:0] fb [128];
    logic [7:0] d;
    int blk = 0;
    int start = 0;
    for (int i = 0; i < len; i++) fb[i] = 8'($urandom);
    for (int i = 0; i < len; i++) begin
      rx_push(fb[i], i == len - 1);
      blk++;
      if (blk == 32 || i == len - 1) begin
        chk("R4 irq raised", {31'b0, irq}, 1);
        bus_rd(6'h20, d);
        chk(i == len - 1 ? "R3 msg end" : "R2 pool full", {24'b0, d},
            {24'b0, exp_ista(i == len - 1, i != len - 1, 1'b0, 1'b0)});
        chk("R5 irq after read", {31'b0, irq}, 0);
        if (i == len - 1) begin
          bus_rd(6'h25, d);
          chk("R3 byte count", {24'b0, d}, blk);
        end
        for (int j = 0; j < blk; j++) begin
          bus_rd(6'($urandom % 32), d);
          chk("R1 window data", {24'b0, d}, {24'b0, fb[start + j]});
        end
        bus_wr(6'h21, 8'h80);
        start += blk;
        blk = 0;
      end
    end
  endtask

  // fill, send, drain the transmit buffer
  task automatic tx_burst(input int n, input bit poke);
    logic [7:0] xb [33];
    logic [7:0] d;
    int exp_n = (n > 32) ? 32 : n;
    int idx = 0;
    bit rdy;
    for (int i = 0; i < n; i++) begin
      xb[i] = 8'($urandom);
      bus_wr(6'($urandom % 32), xb[i]);
    end
    chk("R10 idle before send", {31'b0, tx_valid}, 0);
    bus_wr(6'h21, 8'h08);
    while (idx < exp_n) begin
      @(negedge clk);
      rdy = 1'($urandom);
      if (poke && idx == 1) begin
        bus_sel = 1'b1; bus_we = 1'b1; bus_addr = 6'h03; bus_wdata = 8'hEE;
      end
      #1;
      chk("R10 tx valid", {31'b0, tx_valid}, 1);
      if (rdy) begin
        chk("R10 tx data", {24'b0, tx_data}, {24'b0, xb[idx]});
        chk("R10 tx last", {31'b0, tx_last}, (idx == exp_n - 1) ? 1 : 0);
      end
      tx_ready = rdy;
      @(posedge clk); #1 tx_ready = 1'b0; bus_sel = 1'b0; bus_we = 1'b0;
      if (rdy) idx++;
    end
    chk("R11 returned to host", {31'b0, tx_valid}, 0);
    bus_rd(6'h20, d);
    chk("R11 xpr set", {24'b0, d}, {24'b0, exp_ista(1'b0, 1'b0, 1'b0, 1'b1)});
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog act=running exp=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [7:0] d;
    logic [7:0] b0;
    void'($urandom(32'd1234));
    rst_n = 1'b0; bus_sel = 1'b0; bus_we = 1'b0; bus_addr = '0; bus_wdata = '0;
    rx_valid = 1'b0; rx_data = '0; rx_last = 1'b0; rsc_pulse = 1'b0; tx_ready = 1'b0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (3) @(posedge clk);

    // R4 reset state
    chk("R4 irq after reset", {31'b0, irq}, 0);
    chk("R4 tx idle after reset", {31'b0, tx_valid}, 0);
    bus_rd(6'h20, d);
    chk("R4 status after reset", {24'b0, d}, 0);

    // R6 status change and R5 clear on read
    @(negedge clk); rsc_pulse = 1'b1; @(posedge clk); #1 rsc_pulse = 1'b0;
    chk("R6 irq", {31'b0, irq}, 1);
    bus_rd(6'h20, d);
    chk("R6 rsc bit", {24'b0, d}, {24'b0, exp_ista(1'b0, 1'b0, 1'b1, 1'b0)});
    bus_rd(6'h20, d);
    chk("R5 cleared", {24'b0, d}, 0);

    // R5 event in the same cycle as the read survives
    @(negedge clk);
    rsc_pulse = 1'b1; bus_sel = 1'b1; bus_we = 1'b0; bus_addr = 6'h20;
    #1 d = bus_rdata;
    @(posedge clk); #1 rsc_pulse = 1'b0; bus_sel = 1'b0;
    chk("R5 read value same cycle", {24'b0, d}, 0);
    bus_rd(6'h20, d);
    chk("R5 event kept", {24'b0, d}, {24'b0, exp_ista(1'b0, 1'b0, 1'b1, 1'b0)});

    // directed frame lengths at block edges
    rx_frame(1);
    rx_frame(32);
    rx_frame(33);
    rx_frame(64);

    // R7 release ignored while nothing is held
    for (int i = 0; i < 3; i++) rx_push(8'(i + 8'h10), 1'b0);
    bus_wr(6'h21, 8'h80);
    rx_push(8'h13, 1'b0);
    rx_push(8'h14, 1'b1);
    bus_rd(6'h20, d);
    chk("R7 frame end", {24'b0, d}, {24'b0, exp_ista(1'b1, 1'b0, 1'b0, 1'b0)});
    bus_rd(6'h25, d);
    chk("R7 early release ignored", {24'b0, d}, 5);
    bus_rd(6'h00, d);
    chk("R7 first byte kept", {24'b0, d}, 8'h10);
    // bit 7 clear: still held, so a new byte is dropped (R8)
    bus_wr(6'h21, 8'h7F);
    rx_push(8'hAA, 1'b0);
    bus_rd(6'h27, d);
    chk("R8 overflow set", {24'b0, d}, 1);
    bus_rd(6'h27, d);
    chk("R8 overflow cleared by read", {24'b0, d}, 0);
    bus_rd(6'h20, d);
    chk("R8 no event from dropped byte", {24'b0, d}, 0);
    bus_wr(6'h21, 8'h80);
    // R7 pointer restarts at 0 after release
    rx_push(8'h5A, 1'b1);
    bus_rd(6'h20, d);
    bus_rd(6'h1F, d);
    chk("R7 pointer restarted", {24'b0, d}, 8'h5A);
    bus_wr(6'h21, 8'h80);

    // R8 drop after a pool-full block
    b0 = 8'h00;
    for (int i = 0; i < 32; i++) rx_push(8'(i + 8'h40), 1'b0);
    rx_push(8'hCC, 1'b1);
    bus_rd(6'h20, d);
    chk("R8 only pool full", {24'b0, d}, {24'b0, exp_ista(1'b0, 1'b1, 1'b0, 1'b0)});
    bus_rd(6'h27, d);
    chk("R8 overflow after full block", {24'b0, d}, 1);
    bus_rd(6'h00, b0);
    chk("R8 block intact", {24'b0, b0}, 8'h40);
    bus_wr(6'h21, 8'h80);

    // random frames
    for (int k = 0; k < 10; k++) rx_frame(1 + int'($urandom % 100));

    // transmit path
    bus_wr(6'h21, 8'h08);
    chk("R10 empty send ignored", {31'b0, tx_valid}, 0);
    bus_rd(6'h20, d);
    chk("R10 no xpr on empty send", {24'b0, d}, 0);
    tx_burst(5, 1'b1);
    tx_burst(33, 1'b0);
    tx_burst(1, 1'b0);
    for (int k = 0; k < 4; k++) tx_burst(1 + int'($urandom % 32), 1'b1);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule